// File: doc/BRIEF.md
# System Control and Clock Configuration Register Block

This block is the system-control register file of a small microcontroller-class chip. Software reads fixed identity and capability words from it. It also programs a clock configuration register, nine clock-gating words, a reset-cause word and two power-control words. From the clock configuration the block derives two values. The first is a system clock divider value, presented on a port. The second is a PLL configuration word, looked up from a crystal-frequency field in one of two 16-entry tables. An identity bit fixed at build time picks the table.

A small interrupt controller holds seven raw status bits and a seven-bit mask, and drives one interrupt line. Status bit 6 is set when software powers the PLL up, that is, when a write to the clock configuration register takes the power-down bit from 1 to 0. The gating words leave the block as plain outputs for the clock controller. Actual clock generation, peripheral reset and regulator control sit outside this block.

The bus is a simple single-cycle register port. A write is taken on the rising clock edge when `bus_wr` is high. Reads are combinational from `bus_addr` and carry no side effects. Addresses are word indices.

Top module: `syscon_top`

## Requirements
- R1: After a synchronous active-low reset, the block holds the following values, and the interrupt line is low:
  - the clock configuration register (index 14) reads the `CFG_RST` parameter, and `clk_scale` equals the value derived from it;
  - every running-mode gating word reads `RUN_GATE_RST`, every sleep gating word reads `SLEEP_GATE_RST`, and every deep-sleep gating word reads `DEEP_GATE_RST`;
  - raw status, mask, reset cause, brown-out and regulator words read 0.
- R2: The identity and capability words are read-only parameters and ignore writes. The map is:
  - index 0 is identity word 0, and index 1 is identity word 1;
  - indices 2 to 6 are capability words 0 to 4.
- R3: From the clock edge that takes a write to index 14 onward, `clk_scale` equals 5 × (written bits 26:23 + 1). This gives 5 for a field of 0 and 80 for a field of 15.
- R4: Index 15 reads the PLL configuration word, zero-extended from 16 bits. The word is selected as follows:
  - the table index is bits 9:6 of the clock configuration register;
  - the table used is `PLL_TAB_HI` when bit 16 of identity word 0 is 1, and `PLL_TAB_LO` otherwise.
- R5: A write to index 14 that takes bit 13 from 1 to 0 sets raw status bit 6. A write that leaves bit 13 at 0, leaves it at 1, or raises it, sets no status bit.
- R6: The mask (index 11) keeps written bits 6:0 and reads 0 above them. `irq` is high exactly while raw status AND mask is nonzero.
- R7: Status reads and clears work as follows:
  - index 10 reads raw status;
  - index 12 reads raw status AND mask;
  - a write to index 12 clears each raw status bit written as 1 and leaves the others.
- R8: The reset cause (index 13) keeps written bits 5:0, the brown-out word (index 8) keeps bits 15:0, and the regulator word (index 9) keeps bits 4:0. Upper bits of each read 0.
- R9: Three groups of `GATE_N` 32-bit gating words are fully read/write and drive the outputs, word k in bits 32k+31:32k:
  - running-mode words at indices 16 onward drive `gate_run`;
  - sleep words at indices 20 onward drive `gate_sleep`;
  - deep-sleep words at indices 24 onward drive `gate_deep`.
- R10: The two MAC address words read as follows, with bits 31:24 of both reading 0:
  - index 28 reads MAC bytes 2,1,0, with byte 0 (`MAC_ADDR[7:0]`) in bits 7:0;
  - index 29 reads bytes 5,4,3, with byte 3 in bits 7:0.
- R11: Unmapped indices (for example 7, 19, 30, 31) read 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt, high while masked status is nonzero |
| clk_scale | output | SCALE_W | System clock divider value |
| gate_run | output | 32*GATE_N | Running-mode clock-gating words |
| gate_sleep | output | 32*GATE_N | Sleep-mode clock-gating words |
| gate_deep | output | 32*GATE_N | Deep-sleep clock-gating words |

## Verification
Most internal state in this block appears on the ports within one cycle:
- a wrong divider or gating value shows on `clk_scale` or the gating outputs right after the write edge;
- a wrong status or mask bit shows on `irq` after the same edge.

A wrongly decoded crystal field or table choice shows only when index 15 is read. A wrong sense in the power-down edge detection stays hidden until a mask bit exposes status bit 6. The bench therefore reads back after every write and runs two instances that differ in the table-select identity bit.

// File: rtl/syscon_pkg.sv
// Shared constants for the system-control block: register word indices,
// field positions and widths, and the divider computation.
package syscon_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 6;
    localparam int GATE_STRIDE  = 4;

    // Field layout of the clock configuration register
    localparam int XTAL_LSB     = 6;
    localparam int XTAL_W       = 4;
    localparam int PD_BIT       = 13;
    localparam int DIV_LSB      = 23;
    localparam int DIV_W        = 4;
    localparam int SCALE_W      = $clog2(5 * (2 ** DIV_W) + 1);

    // Identity word 0 bit that selects the high PLL table
    localparam int TAB_SEL_BIT  = 16;

    // Interrupt controller
    localparam int IRQ_W        = 7;
    localparam int LOCK_BIT     = 6;

    // Storage widths of the narrow control words
    localparam int RESC_W       = 6;
    localparam int BOR_W        = 16;
    localparam int LDO_W        = 5;

    // Register word indices
    localparam logic [ADDR_W-1:0] A_ID0      = 6'd0;
    localparam logic [ADDR_W-1:0] A_ID1      = 6'd1;
    localparam logic [ADDR_W-1:0] A_CAP0     = 6'd2;
    localparam logic [ADDR_W-1:0] A_BOR      = 6'd8;
    localparam logic [ADDR_W-1:0] A_LDO      = 6'd9;
    localparam logic [ADDR_W-1:0] A_RAW      = 6'd10;
    localparam logic [ADDR_W-1:0] A_MASK     = 6'd11;
    localparam logic [ADDR_W-1:0] A_MSTAT    = 6'd12;
    localparam logic [ADDR_W-1:0] A_RESC     = 6'd13;
    localparam logic [ADDR_W-1:0] A_CFG      = 6'd14;
    localparam logic [ADDR_W-1:0] A_PLL      = 6'd15;
    localparam logic [ADDR_W-1:0] A_GATE0    = 6'd16;
    localparam logic [ADDR_W-1:0] A_MAC_LO   = 6'd28;
    localparam logic [ADDR_W-1:0] A_MAC_HI   = 6'd29;

    // Divider value for a given divider field
    function automatic logic [SCALE_W-1:0] scale_of(input logic [DIV_W-1:0] f);
        return SCALE_W'(5 * (int'(f) + 1));
    endfunction
endpackage

// File: rtl/syscon_clkcfg.sv
// Clock configuration register with derived divider value and PLL word.
// Assumes: cfg_we is a single-cycle write strobe; the PLL table is fixed at
// build time by TABLE_HI.
module syscon_clkcfg
    import syscon_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG_RST        = 32'h078E_3AD1,
    parameter bit                TABLE_HI       = 1'b0,
    parameter logic [15:0]       PLL_TAB_LO [16] = '{default: 16'h0},
    parameter logic [15:0]       PLL_TAB_HI [16] = '{default: 16'h0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  cfg_q,
    output logic [SCALE_W-1:0] scale_q,
    output logic [15:0]        pll_word,
    output logic               lock_evt
);
    // Holds the configuration word and its derived divider value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= CFG_RST;
            scale_q <= scale_of(CFG_RST[DIV_LSB +: DIV_W]);
        end else if (cfg_we) begin
            cfg_q   <= wdata;
            scale_q <= scale_of(wdata[DIV_LSB +: DIV_W]);
        end
    end

    // PLL power-up request: power-down bit written from 1 to 0
    always_comb lock_evt = cfg_we && cfg_q[PD_BIT] && !wdata[PD_BIT];

    // Table lookup on the crystal field; the table is picked at build time
    generate
        if (TABLE_HI) begin : g_tab_hi
            always_comb pll_word = PLL_TAB_HI[cfg_q[XTAL_LSB +: XTAL_W]];
        end else begin : g_tab_lo
            always_comb pll_word = PLL_TAB_LO[cfg_q[XTAL_LSB +: XTAL_W]];
        end
    endgenerate

    // R3: divider follows the written field on the next edge
    p_scale_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (int'(scale_q) == 5 * (int'($past(wdata[DIV_LSB +: DIV_W])) + 1)));
endmodule

// File: rtl/syscon_irq.sv
// Raw interrupt status, mask and interrupt line.
// Assumes: set_evt and clr_we never coincide (different register indices).
module syscon_irq
    import syscon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_evt,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] status_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;
    logic [IRQ_W-1:0] set_bits;

    // Bits removed by a write-one-to-clear and bits added by the lock event
    always_comb begin
        clr_bits = clr_we ? wdata : '0;
        set_bits = '0;
        set_bits[LOCK_BIT] = set_evt;
    end

    // Status and mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | set_bits;
            if (mask_we) mask_q <= wdata;
        end
    end

    // Interrupt line from masked status
    always_comb irq = |(status_q & mask_q);

    // R7: bits written as one are gone after the clear
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(wdata)) == '0));
    // R5: the lock bit only rises after a lock event
    p_lock_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[LOCK_BIT]) |-> $past(set_evt));
    // R6: an empty mask keeps the line low
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

// File: rtl/syscon_regs.sv
// Plain control words: brown-out, regulator, reset cause and clock gating.
// Assumes: GATE_N <= GATE_STRIDE so gating groups do not overlap.
module syscon_regs
    import syscon_pkg::*;
#(
    parameter int                GATE_N         = 3,
    parameter logic [DATA_W-1:0] RUN_GATE_RST   = 32'h0000_0040,
    parameter logic [DATA_W-1:0] SLEEP_GATE_RST = 32'h0000_0000,
    parameter logic [DATA_W-1:0] DEEP_GATE_RST  = 32'h0000_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [BOR_W-1:0]              bor_q,
    output logic [LDO_W-1:0]              ldo_q,
    output logic [RESC_W-1:0]             resc_q,
    output logic [3*GATE_N-1:0][DATA_W-1:0] gate_q
);
    localparam int WORDS = 3 * GATE_N;

    // Narrow control words, keeping only their stored bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bor_q  <= '0;
            ldo_q  <= '0;
            resc_q <= '0;
        end else if (wr) begin
            if (addr == A_BOR)  bor_q  <= wdata[BOR_W-1:0];
            if (addr == A_LDO)  ldo_q  <= wdata[LDO_W-1:0];
            if (addr == A_RESC) resc_q <= wdata[RESC_W-1:0];
        end
    end

    // One storage word per gating register, grouped run/sleep/deep
    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_gate
            localparam int GRP = i / GATE_N;
            localparam int IDX = i % GATE_N;
            localparam logic [ADDR_W-1:0] WADDR =
                A_GATE0 + ADDR_W'(GRP * GATE_STRIDE + IDX);
            localparam logic [DATA_W-1:0] RST_V =
                (GRP == 0) ? RUN_GATE_RST : (GRP == 1) ? SLEEP_GATE_RST : DEEP_GATE_RST;
            // Gating word storage
            always_ff @(posedge clk) begin
                if (!rst_n)                   gate_q[i] <= RST_V;
                else if (wr && addr == WADDR) gate_q[i] <= wdata;
            end
        end
    endgenerate

    // R8: reset cause keeps exactly the low written bits
    p_resc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_RESC) |=> (resc_q == $past(wdata[RESC_W-1:0])));
endmodule

// File: rtl/syscon_top.sv
// System-control register block: identity/capability words, clock
// configuration with derived divider and PLL word, gating words, reset cause,
// power-control words and a seven-source interrupt controller.
// Assumes: single-cycle writes, combinational side-effect-free reads.
module syscon_top
    import syscon_pkg::*;
#(
    parameter int                GATE_N         = 3,
    parameter int                CAP_N          = 5,
    parameter logic [DATA_W-1:0] ID0            = 32'h0001_0000,
    parameter logic [DATA_W-1:0] ID1            = 32'h1032_E04B,
    parameter logic [DATA_W-1:0] CAP_WORDS [CAP_N] = '{default: 32'h0},
    parameter logic [DATA_W-1:0] CFG_RST        = 32'h078E_3AD1,
    parameter logic [DATA_W-1:0] RUN_GATE_RST   = 32'h0000_0040,
    parameter logic [DATA_W-1:0] SLEEP_GATE_RST = 32'h0000_0040,
    parameter logic [DATA_W-1:0] DEEP_GATE_RST  = 32'h0000_0040,
    parameter logic [47:0]       MAC_ADDR       = 48'h0,
    parameter logic [15:0]       PLL_TAB_LO [16] = '{default: 16'h0},
    parameter logic [15:0]       PLL_TAB_HI [16] = '{default: 16'h0}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     irq,
    output logic [SCALE_W-1:0]       clk_scale,
    output logic [DATA_W*GATE_N-1:0] gate_run,
    output logic [DATA_W*GATE_N-1:0] gate_sleep,
    output logic [DATA_W*GATE_N-1:0] gate_deep
);
    localparam bit TABLE_HI = ID0[TAB_SEL_BIT];

    logic                          cfg_we, mask_we, clr_we, lock_evt;
    logic [DATA_W-1:0]             cfg_q;
    logic [15:0]                   pll_word;
    logic [IRQ_W-1:0]              status_q, mask_q;
    logic [BOR_W-1:0]              bor_q;
    logic [LDO_W-1:0]              ldo_q;
    logic [RESC_W-1:0]             resc_q;
    logic [3*GATE_N-1:0][DATA_W-1:0] gate_q;

    // Write strobes for the registers held in the sub-blocks
    always_comb begin
        cfg_we  = bus_wr && bus_addr == A_CFG;
        mask_we = bus_wr && bus_addr == A_MASK;
        clr_we  = bus_wr && bus_addr == A_MSTAT;
    end

    syscon_clkcfg #(
        .CFG_RST    (CFG_RST),
        .TABLE_HI   (TABLE_HI),
        .PLL_TAB_LO (PLL_TAB_LO),
        .PLL_TAB_HI (PLL_TAB_HI)
    ) u_clkcfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .wdata    (bus_wdata),
        .cfg_q    (cfg_q),
        .scale_q  (clk_scale),
        .pll_word (pll_word),
        .lock_evt (lock_evt)
    );

    syscon_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (lock_evt),
        .mask_we  (mask_we),
        .clr_we   (clr_we),
        .wdata    (bus_wdata[IRQ_W-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    syscon_regs #(
        .GATE_N         (GATE_N),
        .RUN_GATE_RST   (RUN_GATE_RST),
        .SLEEP_GATE_RST (SLEEP_GATE_RST),
        .DEEP_GATE_RST  (DEEP_GATE_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .bor_q  (bor_q),
        .ldo_q  (ldo_q),
        .resc_q (resc_q),
        .gate_q (gate_q)
    );

    // Gating words out to the clock controller
    always_comb begin
        for (int k = 0; k < GATE_N; k++) begin
            gate_run  [k*DATA_W +: DATA_W] = gate_q[k];
            gate_sleep[k*DATA_W +: DATA_W] = gate_q[GATE_N + k];
            gate_deep [k*DATA_W +: DATA_W] = gate_q[2*GATE_N + k];
        end
    end

    // Read multiplexer; unmapped indices read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ID0:    bus_rdata = ID0;
            A_ID1:    bus_rdata = ID1;
            A_BOR:    bus_rdata = DATA_W'(bor_q);
            A_LDO:    bus_rdata = DATA_W'(ldo_q);
            A_RAW:    bus_rdata = DATA_W'(status_q);
            A_MASK:   bus_rdata = DATA_W'(mask_q);
            A_MSTAT:  bus_rdata = DATA_W'(status_q & mask_q);
            A_RESC:   bus_rdata = DATA_W'(resc_q);
            A_CFG:    bus_rdata = cfg_q;
            A_PLL:    bus_rdata = DATA_W'(pll_word);
            A_MAC_LO: bus_rdata = {8'h00, MAC_ADDR[23:0]};
            A_MAC_HI: bus_rdata = {8'h00, MAC_ADDR[47:24]};
            default:  bus_rdata = '0;
        endcase
        for (int k = 0; k < CAP_N; k++)
            if (bus_addr == A_CAP0 + ADDR_W'(k)) bus_rdata = CAP_WORDS[k];
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < GATE_N; k++)
                if (bus_addr == A_GATE0 + ADDR_W'(g*GATE_STRIDE + k))
                    bus_rdata = gate_q[g*GATE_N + k];
    end

    // R5: a power-down 1->0 write shows in raw status on the next edge
    p_lock_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_q[PD_BIT] && !bus_wdata[PD_BIT]) |=> status_q[LOCK_BIT]);
endmodule

// File: tb/syscon_top_tb.sv
// Self-checking bench: directed corners plus seeded random register traffic,
// compared against a bench-side model of the register map.
module syscon_top_tb;
    localparam int GN = 3;
    localparam logic [31:0] ID0_HI = 32'h0001_0101;
    localparam logic [31:0] ID0_LO = 32'h0000_0202;
    localparam logic [31:0] ID1_V  = 32'h1357_9BDF;
    localparam logic [31:0] CAPS [5] = '{32'h0A0A_0001, 32'h0B0B_0002,
        32'h0C0C_0003, 32'h0D0D_0004, 32'h0E0E_0005};
    localparam logic [31:0] CFG_R  = 32'h078E_3AD1;
    localparam logic [31:0] RUN_R  = 32'h0000_0040;
    localparam logic [31:0] SLP_R  = 32'h0000_0011;
    localparam logic [31:0] DP_R   = 32'h0000_0022;
    localparam logic [47:0] MAC    = 48'hC6C5C4_C3C2C1;
    localparam logic [15:0] TAB_LO [16] = '{16'h1100, 16'h1201, 16'h1302,
        16'h1403, 16'h1504, 16'h1605, 16'h1706, 16'h1807, 16'h1908,
        16'h1A09, 16'h1B0A, 16'h1C0B, 16'h1D0C, 16'h1E0D, 16'h1F0E, 16'h200F};
    localparam logic [15:0] TAB_HI [16] = '{16'hE0F0, 16'hE1F1, 16'hE2F2,
        16'hE3F3, 16'hE4F4, 16'hE5F5, 16'hE6F6, 16'hE7F7, 16'hE8F8,
        16'hE9F9, 16'hEAFA, 16'hEBFB, 16'hECFC, 16'hEDFD, 16'hEEFE, 16'hEFFF};

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_alt;
    logic irq, irq_alt;
    logic [6:0] scale, scale_alt;
    logic [32*GN-1:0] g_run, g_slp, g_dp, g_run_a, g_slp_a, g_dp_a;

    always #4 clk = ~clk;

    syscon_top #(.GATE_N(GN), .ID0(ID0_HI), .ID1(ID1_V), .CAP_WORDS(CAPS),
        .CFG_RST(CFG_R), .RUN_GATE_RST(RUN_R), .SLEEP_GATE_RST(SLP_R),
        .DEEP_GATE_RST(DP_R), .MAC_ADDR(MAC), .PLL_TAB_LO(TAB_LO),
        .PLL_TAB_HI(TAB_HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq), .clk_scale(scale),
        .gate_run(g_run), .gate_sleep(g_slp), .gate_deep(g_dp));

    syscon_top #(.GATE_N(GN), .ID0(ID0_LO), .ID1(ID1_V), .CAP_WORDS(CAPS),
        .CFG_RST(CFG_R), .RUN_GATE_RST(RUN_R), .SLEEP_GATE_RST(SLP_R),
        .DEEP_GATE_RST(DP_R), .MAC_ADDR(MAC), .PLL_TAB_LO(TAB_LO),
        .PLL_TAB_HI(TAB_HI)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_alt), .irq(irq_alt),
        .clk_scale(scale_alt), .gate_run(g_run_a), .gate_sleep(g_slp_a),
        .gate_deep(g_dp_a));

    // Bench model of the register state
    logic [31:0] m_cfg;
    logic [6:0]  m_stat, m_mask;
    logic [5:0]  m_resc;
    logic [15:0] m_bor;
    logic [4:0]  m_ldo;
    logic [31:0] m_gate [3*GN];

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cfg = CFG_R; m_stat = '0; m_mask = '0; m_resc = '0; m_bor = '0; m_ldo = '0;
        for (int i = 0; i < 3*GN; i++)
            m_gate[i] = (i < GN) ? RUN_R : (i < 2*GN) ? SLP_R : DP_R;
    endtask

    function automatic int gate_slot(input logic [5:0] a);
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < GN; k++)
                if (int'(a) == 16 + 4*g + k) return g*GN + k;
        return -1;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a, input bit hi);
        int s;
        s = gate_slot(a);
        if (s >= 0) return m_gate[s];
        if (a >= 2 && a <= 6) return CAPS[a-2];
        case (a)
            6'd0:  return hi ? ID0_HI : ID0_LO;
            6'd1:  return ID1_V;
            6'd8:  return {16'h0, m_bor};
            6'd9:  return {27'h0, m_ldo};
            6'd10: return {25'h0, m_stat};
            6'd11: return {25'h0, m_mask};
            6'd12: return {25'h0, m_stat & m_mask};
            6'd13: return {26'h0, m_resc};
            6'd14: return m_cfg;
            6'd15: return {16'h0, hi ? TAB_HI[m_cfg[9:6]] : TAB_LO[m_cfg[9:6]]};
            6'd28: return {8'h0, MAC[23:0]};
            6'd29: return {8'h0, MAC[47:24]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_scale();
        return 32'(5 * (int'(m_cfg[26:23]) + 1));
    endfunction

    task automatic model_wr(input logic [5:0] a, input logic [31:0] d);
        int s;
        s = gate_slot(a);
        if (s >= 0) m_gate[s] = d;
        case (a)
            6'd8:  m_bor = d[15:0];
            6'd9:  m_ldo = d[4:0];
            6'd11: m_mask = d[6:0];
            6'd12: m_stat = m_stat & ~d[6:0];
            6'd13: m_resc = d[5:0];
            6'd14: begin
                if (m_cfg[13] && !d[13]) m_stat[6] = 1'b1;
                m_cfg = d;
            end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a);
        bus_addr = a;
        #1;
        chk(req, rdata, exp_rd(a, 1'b1));
    endtask

    task automatic out_chk(input string req);
        #1;
        chk({req, " scale"}, 32'(scale), exp_scale());
        chk({req, " irq"}, 32'(irq), 32'(|(m_stat & m_mask)));
        for (int k = 0; k < GN; k++) begin
            chk({req, " run"}, g_run[k*32 +: 32], m_gate[k]);
            chk({req, " sleep"}, g_slp[k*32 +: 32], m_gate[GN + k]);
            chk({req, " deep"}, g_dp[k*32 +: 32], m_gate[2*GN + k]);
        end
    endtask

    initial begin : main
        logic [31:0] v;
        logic [5:0] a;
        process::self().srandom(32'd2024);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        out_chk("R1");
        for (int i = 0; i < 32; i++) rd_chk("R1 reset read", 6'(i));

        // R2: identity and capabilities ignore writes
        wr(6'd0, 32'hFFFF_FFFF); wr(6'd4, 32'h0);
        rd_chk("R2 id0", 6'd0); rd_chk("R2 cap2", 6'd4);
        bus_addr = 6'd0; #1; chk("R2 id0 alt", rdata_alt, ID0_LO);

        // R3: divider extremes
        wr(6'd14, 32'h0000_2000); out_chk("R3 field0");
        chk("R3 min", 32'(scale), 32'd5);
        wr(6'd14, 32'h0780_2000); chk("R3 max", 32'(scale), 32'd80);

        // R4: table lookup on both instances
        for (int x = 0; x < 16; x += 5) begin
            wr(6'd14, 32'h0000_2000 | (32'(x) << 6));
            bus_addr = 6'd15; #1;
            chk("R4 hi table", rdata, {16'h0, TAB_HI[x]});
            chk("R4 lo table", rdata_alt, {16'h0, TAB_LO[x]});
        end

        // R5: edge cases of the power-down bit, mask open to observe
        wr(6'd11, 32'h7F);
        wr(6'd14, 32'h0000_2000); rd_chk("R5 1->1 no set", 6'd10);
        wr(6'd14, 32'h0000_0000); rd_chk("R5 1->0 sets", 6'd10);
        chk("R5 set bit6", rdata, 32'h40); out_chk("R5");
        wr(6'd12, 32'h40);
        wr(6'd14, 32'h0000_0000); rd_chk("R5 0->0 no set", 6'd10);
        wr(6'd14, 32'h0000_2000); rd_chk("R5 0->1 no set", 6'd10);
        chk("R5 none", rdata, 32'h0);

        // R6/R7: mask gating and selective clear
        wr(6'd14, 32'h0000_0000);
        wr(6'd11, 32'hFFFF_FF3F); rd_chk("R6 mask width", 6'd11);
        out_chk("R6 masked off"); chk("R6 irq low", 32'(irq), 32'd0);
        rd_chk("R7 masked read", 6'd12);
        wr(6'd11, 32'h40); out_chk("R6 unmasked"); chk("R6 irq high", 32'(irq), 32'd1);
        rd_chk("R7 masked read set", 6'd12);
        wr(6'd12, 32'h3F); rd_chk("R7 clear other bits keeps", 6'd10);
        wr(6'd12, 32'h40); rd_chk("R7 cleared", 6'd10); out_chk("R7");

        // R8: widths of narrow words
        wr(6'd13, 32'hFFFF_FFFF); rd_chk("R8 resc", 6'd13);
        wr(6'd8, 32'hFFFF_FFFF);  rd_chk("R8 bor", 6'd8);
        wr(6'd9, 32'hFFFF_FFFF);  rd_chk("R8 ldo", 6'd9);

        // R9: gating words
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < GN; k++) begin
                wr(6'(16 + 4*g + k), 32'hA5A5_0000 | 32'(g*16 + k));
                rd_chk("R9 gate", 6'(16 + 4*g + k));
            end
        out_chk("R9");

        // R10: MAC words
        rd_chk("R10 mac lo", 6'd28); chk("R10 byte0", rdata, 32'h00C3C2C1);
        rd_chk("R10 mac hi", 6'd29);

        // R11: unmapped writes do nothing
        wr(6'd7, 32'hFFFF_FFFF); wr(6'd19, 32'hFFFF_FFFF); wr(6'd31, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) rd_chk("R11 map unchanged", 6'(i));
        out_chk("R11");

        // Seeded random traffic, every requirement's state read back
        for (int it = 0; it < 400; it++) begin
            a = 6'($urandom_range(0, 31));
            v = $urandom;
            if (it % 4 == 0) a = 6'd14;
            wr(a, v);
            rd_chk("R3-R9 random readback", a);
            out_chk("R3 R6 R9 random outputs");
            a = 6'($urandom_range(0, 31));
            rd_chk("R7 R10 R11 random read", a);
            bus_addr = 6'd15; #1;
            chk("R4 random lo table", rdata_alt, {16'h0, TAB_LO[m_cfg[9:6]]});
        end

        // R1: reset in mid-run returns to defaults
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        model_reset();
        out_chk("R1 re-reset");
        for (int i = 0; i < 32; i++) rd_chk("R1 re-reset read", 6'(i));
        done = 1'b1;
    end

    initial begin : watchdog
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule